// File: doc/BRIEF.md
# Codec Host Serial Port with Control Frames

This block is the synchronous serial port between a host processor and a sampled-data codec. In every frame period it takes one 16-bit word from the host on the serial input, for the digital-to-analog path, and sends one 16-bit converter sample back on the serial output. Words travel most significant bit first, in two's complement. The converter side is reached through two plain parallel ports. One port presents each received word with a one-cycle valid strobe. The other port is sampled at frame start, and a one-cycle take strobe marks the moment of sampling.

A frame can be a plain data frame, or it can be followed halfway through the period by a secondary frame. The secondary frame rewrites the 16-bit configuration register and returns its current value to the host. Whether a secondary frame follows is decided by the two mode pins, which are latched when the primary sync rises. In software mode the decision comes from the transmit word's least significant bit. In master mode the block generates the frame sync itself, once per period plus a mid-period sync when one is needed. In slave mode the host supplies every sync. A timeslot input moves the 16-bit window from bit slots 1 to 16 to bit slots 17 to 32, so that two ports can share one bus.

The block runs on the serial bit clock. Input bits are sampled on its rising edge, and the output bit changes on the same edge.

Top module: `afe_host_port`

## Requirements
- R1: While reset is low, and after it is released, the configuration output reads 0x0300 (bits 9 and 8 set, all others clear), both strobes are low, and the first frame sync after reset starts a primary frame.
- R2: In master mode, the sync output `fs_o` is low for exactly one clock at the start of each frame period. With no secondary frame pending, it goes low again FRAME_LEN clocks later. A frame starts at the rising clock edge where the active sync is low and was high at the previous edge.
- R3: With timeslot 0, the output pin carries the parallel input word, MSB first, in the 16 clock periods that follow the start edge. The input pin is sampled, MSB first, at the 16 edges that end those periods. In the clock after the last bit, `dac_valid_o` is high for one cycle with the received word on `dac_word_o`.
- R4: With timeslot 1, the window moves to bit slots 17 to 32 after the start edge. The output pin is 0 in slots 1 to 16.
- R5: The mode pins are latched only at the rising edge of a primary sync. A change on them later in the frame does not affect that frame.
- R6: Mode 00 (software) delivers bits 15..1 of the received word with bit 0 forced to 0. A received bit 0 of 1 requests a secondary frame, and a bit 0 of 0 does not.
- R7: Mode 01 delivers all 16 bits and never requests a secondary frame. Modes 10 and 11 deliver all 16 bits and request a secondary frame after every primary frame.
- R8: In master mode, a requested secondary sync is issued FRAME_LEN/2 clocks after the primary sync.
- R9: A secondary frame sends the current configuration on the output pin and takes the received word as the new configuration. It produces no `dac_valid_o` and no `adc_take_o` strobe.
- R10: A configuration word written in a secondary frame appears on `cfg_o` only at the start of the next primary frame.
- R11: In slave mode, frames are started by `fs_i`. A new falling edge during a transfer abandons the transfer and restarts the bit count, and no word is delivered for the abandoned frame.
- R12: `adc_take_o` is high for one clock after each primary start edge. The word sent in that frame is the value on `adc_word_i` at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_i | input | 1 | 1: block drives frame sync; 0: sync taken from `fs_i` |
| ts_i | input | 1 | Timeslot select: 0 for slots 1-16, 1 for slots 17-32 |
| hc_i | input | 2 | Mode pins, latched at primary sync rise |
| fs_i | input | 1 | External frame sync, active low (slave mode) |
| fs_o | output | 1 | Generated frame sync, active low (master mode) |
| din_i | input | 1 | Serial data from host |
| dout_o | output | 1 | Serial data to host |
| dac_word_o | output | 16 | Last received sample word |
| dac_valid_o | output | 1 | One-cycle strobe for `dac_word_o` |
| adc_word_i | input | 16 | Sample word to send in the next primary frame |
| adc_take_o | output | 1 | One-cycle strobe after `adc_word_i` was sampled |
| cfg_o | output | 16 | Active configuration register |

## Verification
Most faults in this block show up within one frame period as a wrongly timed word. A bit counter that is off by one, or a timeslot that is ignored, shifts or corrupts the serial word at once, and the host sees the wrong value within 16 or 32 clocks. A pending flag or a frame-kind flag in the wrong state is slower to surface: the mid-period sync appears or goes missing half a period later, or a data word is taken as configuration, so the checks measure how many clocks separate the syncs. A staging register that is applied at the wrong time changes `cfg_o` outside a primary frame start, which the next readback exposes within one period.

// File: rtl/afe_port_pkg.sv
// Shared types and helpers for the codec host serial port.
// Assumes a 16-bit word; mode pin encoding is fixed by the pin protocol.
package afe_port_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        HC_SOFT     = 2'b00,
        HC_HARD     = 2'b01,
        HC_HARD_CTL = 2'b10,
        HC_HARD_CT2 = 2'b11
    } hc_mode_e;

    // True when the frame just finished must be followed by a secondary frame.
    function automatic logic ctrl_wanted(input hc_mode_e mode, input logic lsb);
        return (mode == HC_HARD_CTL) || (mode == HC_HARD_CT2) || ((mode == HC_SOFT) && lsb);
    endfunction

endpackage

// File: rtl/afe_fs_timer.sv
// Master-mode frame sync generator.
// Produces a one-clock low pulse at count 0 of each period and, when a
// secondary frame is pending, a second pulse at the half period.
// Assumes FRAME_LEN is even and at least 66, so that a timeslot-1 window ends before the half point.
module afe_fs_timer #(
    parameter int FRAME_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    output logic fs_n_o
);
    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam int HALF  = FRAME_LEN / 2;

    logic [CNT_W-1:0] cnt_q;

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CNT_W'(FRAME_LEN - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign fs_n_o = !((cnt_q == '0) || ((cnt_q == CNT_W'(HALF)) && pend_i));

endmodule

// File: rtl/afe_serial_lane.sv
// Bidirectional shift lane for one transfer.
// Loads the outgoing word at the start edge and shifts during a 16-bit
// window placed in slot 0 or slot 1 after the start.
// Assumes W is a power of two. A new start_i restarts the lane at any time.
module afe_serial_lane #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         ts_i,
    input  logic [W-1:0] load_i,
    input  logic         din_i,
    output logic         dout_o,
    output logic         last_o,
    output logic [W-1:0] word_o
);
    localparam int SLOT_W = $clog2(W);
    localparam int POS_W  = SLOT_W + 1;

    logic             active_q;
    logic [POS_W-1:0] pos_q;
    logic             ts_q;
    logic [W-1:0]     tx_q;
    logic [W-1:0]     rx_q;
    logic             in_win;

    assign in_win = active_q && (pos_q[POS_W-1] == ts_q);
    assign last_o = in_win && (pos_q[SLOT_W-1:0] == {SLOT_W{1'b1}});
    assign dout_o = in_win && tx_q[W-1];
    assign word_o = {rx_q[W-2:0], din_i};

    // Bit position tracking and shifting for the active transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pos_q    <= '0;
            ts_q     <= 1'b0;
            tx_q     <= '0;
            rx_q     <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            pos_q    <= '0;
            ts_q     <= ts_i;
            tx_q     <= load_i;
        end else if (active_q) begin
            pos_q <= pos_q + 1'b1;
            if (in_win) begin
                tx_q <= {tx_q[W-2:0], 1'b0};
                rx_q <= {rx_q[W-2:0], din_i};
            end
            if (last_o)
                active_q <= 1'b0;
        end
    end

endmodule

// File: rtl/afe_ctrl_reg.sv
// Configuration register with a staging copy.
// A secondary-frame write lands in staging; the active copy takes it at
// the next primary frame start, so one frame always sees one setting.
module afe_ctrl_reg #(
    parameter int             W         = 16,
    parameter logic [W-1:0]   RESET_VAL = 16'h0300
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         apply_i,
    output logic [W-1:0] cfg_o
);
    logic [W-1:0] staged_q;
    logic         staged_v_q;

    // Stage writes and promote them on primary frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q   <= RESET_VAL;
            staged_v_q <= 1'b0;
            cfg_o      <= RESET_VAL;
        end else if (wr_i) begin
            staged_q   <= wdata_i;
            staged_v_q <= 1'b1;
        end else if (apply_i && staged_v_q) begin
            cfg_o      <= staged_q;
            staged_v_q <= 1'b0;
        end
    end

endmodule

// File: rtl/afe_host_port.sv
// Codec host serial port: frame sync handling, primary/secondary frame
// sequencing, mode pin latching and sample word exchange.
// Assumes clk is the serial bit clock and fs_i is synchronous to it.
module afe_host_port
    import afe_port_pkg::*;
#(
    parameter int                 WORD_W_P  = WORD_W,
    parameter int                 FRAME_LEN = 128,
    parameter logic [WORD_W_P-1:0] RESET_CFG = 16'h0300
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_i,
    input  logic                ts_i,
    input  logic [1:0]          hc_i,
    input  logic                fs_i,
    output logic                fs_o,
    input  logic                din_i,
    output logic                dout_o,
    output logic [WORD_W_P-1:0] dac_word_o,
    output logic                dac_valid_o,
    input  logic [WORD_W_P-1:0] adc_word_i,
    output logic                adc_take_o,
    output logic [WORD_W_P-1:0] cfg_o
);
    logic                fs_gen_n;
    logic                fs_n;
    logic                fs_q;
    logic                start;
    logic                rise;
    logic                sec_q;
    logic                pend_q;
    hc_mode_e            mode_q;
    logic                lane_last;
    logic [WORD_W_P-1:0] lane_word;
    logic [WORD_W_P-1:0] lane_load;

    afe_fs_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_q),
        .fs_n_o (fs_gen_n)
    );

    assign fs_o      = fs_gen_n;
    assign fs_n      = master_i ? fs_gen_n : fs_i;
    assign start     = fs_q && !fs_n;
    assign rise      = !fs_q && fs_n;
    assign lane_load = pend_q ? cfg_o : adc_word_i;

    afe_serial_lane #(.W(WORD_W_P)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .ts_i    (ts_i),
        .load_i  (lane_load),
        .din_i   (din_i),
        .dout_o  (dout_o),
        .last_o  (lane_last),
        .word_o  (lane_word)
    );

    afe_ctrl_reg #(.W(WORD_W_P), .RESET_VAL(RESET_CFG)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (lane_last && sec_q),
        .wdata_i (lane_word),
        .apply_i (start && !pend_q),
        .cfg_o   (cfg_o)
    );

    // Sync edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= 1'b1;
        else        fs_q <= fs_n;
    end

    // Frame kind, mode latch, secondary request and parallel strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q       <= 1'b0;
            pend_q      <= 1'b0;
            mode_q      <= HC_SOFT;
            dac_word_o  <= '0;
            dac_valid_o <= 1'b0;
            adc_take_o  <= 1'b0;
        end else begin
            dac_valid_o <= 1'b0;
            adc_take_o  <= start && !pend_q;
            if (start) begin
                sec_q  <= pend_q;
                pend_q <= 1'b0;
            end else if (lane_last && !sec_q) begin
                dac_word_o  <= (mode_q == HC_SOFT) ? {lane_word[WORD_W_P-1:1], 1'b0} : lane_word;
                dac_valid_o <= 1'b1;
                pend_q      <= ctrl_wanted(mode_q, lane_word[0]);
            end
            if (rise && !sec_q)
                mode_q <= hc_mode_e'(hc_i);
        end
    end

endmodule

// File: rtl/afe_host_port_chk.sv
// Property checker for the codec host serial port, attached by bind.
module afe_host_port_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         master_i,
    input logic         fs_o,
    input logic         dac_valid_o,
    input logic         adc_take_o,
    input logic [W-1:0] cfg_o
);
    assert_fs_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && !fs_o) |=> fs_o);

    assert_dac_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid_o |=> !dac_valid_o);

    assert_take_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        adc_take_o |=> !adc_take_o);

    assert_cfg_at_primary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> adc_take_o);

    assert_take_not_at_delivery_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && dac_valid_o) |-> !adc_take_o);
endmodule

bind afe_host_port afe_host_port_chk #(.W(WORD_W_P)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_i    (master_i),
    .fs_o        (fs_o),
    .dac_valid_o (dac_valid_o),
    .adc_take_o  (adc_take_o),
    .cfg_o       (cfg_o)
);

// File: tb/tb_afe_host_port.sv
module tb_afe_host_port;
    localparam int FL = 128;

    logic        clk = 1'b0;
    logic        rst_n, master, ts, fs_in, din;
    logic [1:0]  hc;
    logic [15:0] adc_word;
    logic        fs_out, dout, dac_valid, adc_take;
    logic [15:0] dac_word, cfg;

    int          checks = 0, fails = 0;
    logic [15:0] got, dw_seen;
    logic        dv_seen, take_seen, idle_bad;
    int          waited;
    int          late_idx = -1;
    logic [1:0]  late_hc = 2'b00;
    bit          done = 0;

    always #4 clk = ~clk;

    afe_host_port #(.FRAME_LEN(FL)) dut (
        .clk(clk), .rst_n(rst_n), .master_i(master), .ts_i(ts), .hc_i(hc),
        .fs_i(fs_in), .fs_o(fs_out), .din_i(din), .dout_o(dout),
        .dac_word_o(dac_word), .dac_valid_o(dac_valid), .adc_word_i(adc_word),
        .adc_take_o(adc_take), .cfg_o(cfg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One transfer; called at a falling clock edge.
    task automatic xfer(input bit slave, input bit slot, input logic [15:0] tx);
        ts = slot; idle_bad = 1'b0; waited = 0;
        if (slave) begin
            fs_in = 1'b0; @(negedge clk); fs_in = 1'b1;
        end else begin
            while (fs_out !== 1'b0) begin @(negedge clk); waited++; end
            @(negedge clk);
        end
        take_seen = adc_take;
        if (slot)
            for (int i = 0; i < 16; i++) begin
                if (dout !== 1'b0) idle_bad = 1'b1;
                din = 1'b1; @(negedge clk);
            end
        for (int k = 15; k >= 0; k--) begin
            din = tx[k]; got[k] = dout;
            if (k == late_idx) hc = late_hc;
            @(negedge clk);
        end
        dv_seen = dac_valid; dw_seen = dac_word; din = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; master = 1'b1; hc = 2'b01; ts = 1'b0; fs_in = 1'b1; din = 1'b0;
        adc_word = 16'h1E0F;
        repeat (3) @(negedge clk);
        chk("R1 cfg default", cfg, 16'h0300);
        chk("R1 dac_valid idle", dac_valid, 0);
        chk("R1 adc_take idle", adc_take, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_hw_data;
        int lows, n;
        xfer(0, 0, 16'hA5C3);
        chk("R3 dout word", got, 16'h1E0F);
        chk("R3 dac_valid", dv_seen, 1);
        chk("R3 dac word", dw_seen, 16'hA5C3);
        chk("R12 take on primary", take_seen, 1);
        lows = 0;
        for (int i = 0; i < 90; i++) begin @(negedge clk); if (fs_out === 1'b0) lows++; end
        chk("R7 mode01 no secondary", lows, 0);
        while (fs_out !== 1'b0) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (fs_out !== 1'b0);
        chk("R2 sync period", n, FL);
    endtask

    task automatic t_soft;
        hc = 2'b00;
        xfer(0, 0, 16'h8642);
        chk("R6 lsb0 word", dw_seen, 16'h8642);
        xfer(0, 0, 16'h7777);
        chk("R6 lsb0 no secondary", waited, FL - 17);
        chk("R6 lsb cleared", dw_seen, 16'h7776);
        xfer(0, 0, 16'h05A8);
        chk("R8 secondary at half", waited, FL / 2 - 17);
        chk("R9 readback", got, 16'h0300);
        chk("R9 no dac strobe", dv_seen, 0);
        chk("R9 no take strobe", take_seen, 0);
        chk("R10 cfg held", cfg, 16'h0300);
        xfer(0, 0, 16'h1110);
        chk("R10 cfg applied", cfg, 16'h05A8);
        chk("R12 take resumes", take_seen, 1);
    endtask

    task automatic t_latch;
        hc = 2'b00; late_idx = 13; late_hc = 2'b01;
        xfer(0, 0, 16'h0F0F);
        late_idx = -1;
        xfer(0, 0, 16'h05A8);
        chk("R5 late pins ignored", waited, FL / 2 - 17);
        chk("R9 readback new", got, 16'h05A8);
        xfer(0, 0, 16'h3333);
        chk("R7 mode01 full word", dw_seen, 16'h3333);
        xfer(0, 0, 16'h4444);
        chk("R7 mode01 lsb1 no secondary", waited, FL - 17);
    endtask

    task automatic t_hwctl;
        hc = 2'b10;
        xfer(0, 0, 16'h2222);
        chk("R7 mode10 word", dw_seen, 16'h2222);
        xfer(0, 0, 16'h05A8);
        chk("R7 mode10 secondary", waited, FL / 2 - 17);
        hc = 2'b01;
    endtask

    task automatic t_slot;
        xfer(0, 0, 16'h1234);
        xfer(0, 1, 16'hC001);
        chk("R4 slot1 dout", got, 16'h1E0F);
        chk("R4 slot1 word", dw_seen, 16'hC001);
        chk("R4 slot0 idle", idle_bad, 0);
        ts = 1'b0;
    endtask

    task automatic t_slave;
        logic bad;
        master = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 cfg after reset", cfg, 16'h0300);
        rst_n = 1'b1; hc = 2'b10; adc_word = 16'h5AA5;
        repeat (3) @(negedge clk);
        xfer(1, 0, 16'h9876);
        chk("R11 slave dout", got, 16'h5AA5);
        chk("R11 slave word", dw_seen, 16'h9876);
        repeat (5) @(negedge clk);
        xfer(1, 0, 16'h0123);
        chk("R11 slave secondary readback", got, 16'h0300);
        chk("R9 slave no dac strobe", dv_seen, 0);
        hc = 2'b01;
        repeat (4) @(negedge clk);
        fs_in = 1'b0; @(negedge clk); fs_in = 1'b1;
        bad = 1'b0;
        for (int i = 0; i < 5; i++) begin
            din = i[0]; @(negedge clk);
            if (dac_valid !== 1'b0) bad = 1'b1;
        end
        xfer(1, 0, 16'hBEEF);
        chk("R11 abort no strobe", bad, 0);
        chk("R11 restart word", dw_seen, 16'hBEEF);
        chk("R11 restart dout", got, 16'h5AA5);
        chk("R10 slave cfg applied", cfg, 16'h0123);
    endtask

    initial begin
        t_reset;
        @(negedge clk);
        t_hw_data;
        t_soft;
        t_latch;
        t_hwctl;
        t_slot;
        t_slave;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule